// File: doc/BRIEF.md
# Light-Pen Construction Mode Controller

This block sequences the operator's actions at a light-pen drawing console. Mode buttons choose one of four working modes: straight-line construction, circle construction, erase, and freehand writing. In the two construction modes, enabled pen hits pick a first and a second construction point. A lamp output lights once both points are held, and an execute button then issues a draw command that says whether the figure is a line or a circle. In the circle case the first point is the centre and the second is a point on the circumference.

Once a figure is on the screen, the operator can indicate a point again. A new first point moves the figure and keeps its size, which is how parallel lines are made. In circle mode, holding the second-point select level while hitting the pen replaces the circumference point instead, so the circle is redrawn around the same centre with a new radius. Erase mode marks traced positions as pending and removes them only on an execute-erase press. Freehand mode opens a write gate for as long as the pen enable is held. A separate button throws away all construction points at once.

Every button, the pen hit and the two pen levels pass through a synchroniser. Each press becomes a single event. The controller only tells the datapath when to capture and what to draw. Coordinate counting and waveform generation are outside this block.

Top module: `sketch_mode_ctrl`

## Requirements
- R1: Pressing bit i of `mode_btn` selects mode i. `mode_o` encodes line=0, circle=1, erase=2, write=3. Reset selects line. If several bits rise in the same cycle, the lowest index wins.
- R2: Each rising edge of a button or of `pen_hit` produces exactly one event, however long the input stays high. Every input reaches the outputs three clock edges after it changes.
- R3: In line or circle mode, a pen hit while `pen_en` is high pulses `lat_p1` if no first point is held, and otherwise pulses `lat_p2` if no second point is held. A pen hit while `pen_en` is low does nothing.
- R4: `con_ready` is high exactly while both points are held. An execute-construct press then pulses `draw_go`, with `draw_circle` at 1 for circle mode and 0 for line mode. With `con_ready` low, the press is ignored.
- R5: After a draw, and while both points are held, an enabled hit without the second-point select pulses `lat_p1`. `draw_go` of the same kind follows one cycle later.
- R6: In circle mode after a draw, an enabled hit with `pick_second` high pulses `lat_p2`, and a circle `draw_go` follows one cycle later.
- R7: In erase mode, every pen hit pulses `erase_mark`, whatever the level of `pen_en`. An execute-erase press pulses `erase_go` only when marks are pending, and the press clears them.
- R8: `write_gate` is high exactly while the mode is write and `pen_en` is held.
- R9: An erase-point press pulses `pts_clear`, drops both points, turns `con_ready` off and forgets the drawn figure.
- R10: Any mode press drops both points and turns `con_ready` off.
- R11: Pen hits give no point strobe outside the line and circle modes, and give no `erase_mark` outside erase mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_btn | input | 4 | Mode buttons: line, circle, erase, write |
| pen_en | input | 1 | Pen enable button level |
| pen_hit | input | 1 | Pen hit pulse |
| pick_second | input | 1 | Level selecting re-indication of the second point |
| exec_con_btn | input | 1 | Execute-construct button |
| exec_era_btn | input | 1 | Execute-erase button |
| erase_pt_btn | input | 1 | Clear-all-points button |
| mode_o | output | 2 | Current mode |
| lat_p1 | output | 1 | One-cycle strobe to latch point one |
| lat_p2 | output | 1 | One-cycle strobe to latch point two |
| con_ready | output | 1 | Execute-construct lamp |
| draw_go | output | 1 | One-cycle draw command |
| draw_circle | output | 1 | Figure kind that goes with `draw_go` |
| erase_mark | output | 1 | One-cycle strobe marking a traced position pending |
| erase_go | output | 1 | One-cycle strobe removing the pending marks |
| pts_clear | output | 1 | One-cycle strobe clearing all construction points |
| write_gate | output | 1 | Freehand write enable |

## Verification
Most results appear on the third clock edge after an input changes: two synchroniser flops, then the output register. A redraw that follows a re-indication comes one edge later, on the fourth.

The bench holds each press for several cycles and lets everything settle before it compares anything. The one-cycle strobes are counted at every rising edge, and the bench checks the cumulative counts, so a missing or a doubled pulse shows up.

The write gate is sampled right after the second edge and right after the third edge, to pin its latency exactly. Its high time is also counted against the hold time of `pen_en`.

// File: rtl/skc_pkg.sv
package skc_pkg;

    typedef enum logic [1:0] {
        MD_LINE  = 2'd0,
        MD_CIRC  = 2'd1,
        MD_ERASE = 2'd2,
        MD_WRITE = 2'd3
    } mode_e;

    localparam int N_MODES = 4;

    typedef struct packed {
        mode_e mode;
        logic  p1v;
        logic  p2v;
        logic  drawn;
        logic  redraw;
        logic  pend;
        logic  lat_p1;
        logic  lat_p2;
        logic  draw_go;
        logic  draw_circle;
        logic  erase_mark;
        logic  erase_go;
        logic  pts_clear;
        logic  write_gate;
    } seq_state_t;

endpackage

// File: rtl/skc_sync.sv
module skc_sync #(
    parameter int W      = 10,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q[0] <= '0;
            prev_q   <= '0;
        end else begin
            stg_q[0] <= raw;
            prev_q   <= stg_q[STAGES-1];
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign lvl  = stg_q[STAGES-1];
    assign rise = lvl & ~prev_q;

    // R2: one press never yields events on two consecutive cycles
    a_r2_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/skc_seq.sv
module skc_seq
    import skc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MODES-1:0] mode_ev,
    input  logic               hit_ev,
    input  logic               excon_ev,
    input  logic               exera_ev,
    input  logic               ept_ev,
    input  logic               en_lvl,
    input  logic               pick_lvl,
    output seq_state_t         st
);
    seq_state_t st_d, st_q;
    logic       build_mode;

    always_comb begin
        st_d             = st_q;
        build_mode       = (st_q.mode == MD_LINE) || (st_q.mode == MD_CIRC);
        st_d.lat_p1      = 1'b0;
        st_d.lat_p2      = 1'b0;
        st_d.erase_mark  = 1'b0;
        st_d.erase_go    = 1'b0;
        st_d.pts_clear   = 1'b0;
        st_d.redraw      = 1'b0;
        st_d.draw_go     = st_q.redraw;
        if (st_q.redraw) st_d.draw_circle = (st_q.mode == MD_CIRC);

        if (mode_ev != '0) begin
            for (int m = N_MODES - 1; m >= 0; m--) begin
                if (mode_ev[m]) st_d.mode = mode_e'(m);
            end
            st_d.p1v    = 1'b0;
            st_d.p2v    = 1'b0;
            st_d.drawn  = 1'b0;
            st_d.redraw = 1'b0;
        end else if (ept_ev) begin
            st_d.p1v       = 1'b0;
            st_d.p2v       = 1'b0;
            st_d.drawn     = 1'b0;
            st_d.redraw    = 1'b0;
            st_d.pts_clear = 1'b1;
        end else if (excon_ev && build_mode && st_q.p1v && st_q.p2v) begin
            st_d.draw_go     = 1'b1;
            st_d.draw_circle = (st_q.mode == MD_CIRC);
            st_d.drawn       = 1'b1;
        end else if (exera_ev && st_q.mode == MD_ERASE && st_q.pend) begin
            st_d.erase_go = 1'b1;
            st_d.pend     = 1'b0;
        end else if (hit_ev) begin
            if (st_q.mode == MD_ERASE) begin
                st_d.erase_mark = 1'b1;
                st_d.pend       = 1'b1;
            end else if (build_mode && en_lvl) begin
                if (!st_q.p1v) begin
                    st_d.lat_p1 = 1'b1;
                    st_d.p1v    = 1'b1;
                end else if (!st_q.p2v) begin
                    st_d.lat_p2 = 1'b1;
                    st_d.p2v    = 1'b1;
                end else if (st_q.mode == MD_CIRC && pick_lvl) begin
                    st_d.lat_p2 = 1'b1;
                    st_d.redraw = st_q.drawn;
                end else begin
                    st_d.lat_p1 = 1'b1;
                    st_d.redraw = st_q.drawn;
                end
            end
        end

        st_d.write_gate = (st_d.mode == MD_WRITE) && en_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_LINE;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

    // R4: a draw command only follows a cycle in which the lamp was lit
    a_r4_draw_after_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.draw_go |-> $past(st_q.p1v && st_q.p2v));
    // R3: latching point two leaves both points held
    a_r3_p2_lights_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lat_p2 |-> (st_q.p1v && st_q.p2v));
    // R8: the write gate is only open in write mode
    a_r8_gate_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.write_gate |-> (st_q.mode == MD_WRITE));
    // R7: erase execution happens only in erase mode
    a_r7_erase_go_mode: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.erase_go |-> (st_q.mode == MD_ERASE));
    // R9: clearing points drops the lamp
    a_r9_clear_drops_lamp: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pts_clear |-> !(st_q.p1v || st_q.p2v));
    // R10: a mode change leaves no point held
    a_r10_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode != $past(st_q.mode)) |-> !(st_q.p1v || st_q.p2v));
    // R11: point and mark strobes are mutually exclusive
    a_r11_strobes_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.lat_p1, st_q.lat_p2, st_q.erase_mark}));

endmodule

// File: rtl/sketch_mode_ctrl.sv
module sketch_mode_ctrl
    import skc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] mode_btn,
    input  logic       pen_en,
    input  logic       pen_hit,
    input  logic       pick_second,
    input  logic       exec_con_btn,
    input  logic       exec_era_btn,
    input  logic       erase_pt_btn,
    output logic [1:0] mode_o,
    output logic       lat_p1,
    output logic       lat_p2,
    output logic       con_ready,
    output logic       draw_go,
    output logic       draw_circle,
    output logic       erase_mark,
    output logic       erase_go,
    output logic       pts_clear,
    output logic       write_gate
);
    localparam int IDX_HIT  = N_MODES;
    localparam int IDX_XCON = N_MODES + 1;
    localparam int IDX_XERA = N_MODES + 2;
    localparam int IDX_EPT  = N_MODES + 3;
    localparam int IDX_EN   = N_MODES + 4;
    localparam int IDX_PICK = N_MODES + 5;
    localparam int NIN      = N_MODES + 6;

    logic [NIN-1:0] raw, lvl, rise;
    seq_state_t     st;

    assign raw = {pick_second, pen_en, erase_pt_btn, exec_era_btn,
                  exec_con_btn, pen_hit, mode_btn};

    skc_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (raw),
        .lvl  (lvl),
        .rise (rise)
    );

    skc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_ev (rise[N_MODES-1:0]),
        .hit_ev  (rise[IDX_HIT]),
        .excon_ev(rise[IDX_XCON]),
        .exera_ev(rise[IDX_XERA]),
        .ept_ev  (rise[IDX_EPT]),
        .en_lvl  (lvl[IDX_EN]),
        .pick_lvl(lvl[IDX_PICK]),
        .st      (st)
    );

    assign mode_o      = st.mode;
    assign lat_p1      = st.lat_p1;
    assign lat_p2      = st.lat_p2;
    assign con_ready   = st.p1v & st.p2v;
    assign draw_go     = st.draw_go;
    assign draw_circle = st.draw_circle;
    assign erase_mark  = st.erase_mark;
    assign erase_go    = st.erase_go;
    assign pts_clear   = st.pts_clear;
    assign write_gate  = st.write_gate;

endmodule

// File: tb/sketch_mode_ctrl_test.sv
`timescale 1ns/1ps
module sketch_mode_ctrl_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [3:0] mode_btn = '0;
    logic pen_en = 0, pen_hit = 0, pick_second = 0;
    logic exec_con_btn = 0, exec_era_btn = 0, erase_pt_btn = 0;
    logic [1:0] mode_o;
    logic lat_p1, lat_p2, con_ready, draw_go, draw_circle;
    logic erase_mark, erase_go, pts_clear, write_gate;

    always #2.5 clk = ~clk;

    sketch_mode_ctrl uut (.*);

    int n_chk = 0, n_bad = 0;
    int c_p1 = 0, c_p2 = 0, c_dr = 0, c_mk = 0, c_eg = 0, c_clr = 0, c_wg = 0;
    bit done = 0;

    always @(posedge clk) if (rst_n) begin
        c_p1 <= c_p1 + int'(lat_p1);
        c_p2 <= c_p2 + int'(lat_p2);
        c_dr <= c_dr + int'(draw_go);
        c_mk <= c_mk + int'(erase_mark);
        c_eg <= c_eg + int'(erase_go);
        c_clr <= c_clr + int'(pts_clear);
        c_wg <= c_wg + int'(write_gate);
    end

    // act: 0 mode press (arg=mode), 1 pen hit (arg[0]=enable, arg[1]=pick_second),
    //      2 execute-construct, 3 execute-erase, 4 erase-point
    typedef struct packed {
        logic [2:0] act;
        logic [1:0] arg;
        logic [1:0] mode;
        logic       rdy;
        logic [7:0] p1, p2, dr;
        logic       kind;
        logic [7:0] mk, eg;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd0, 2'd0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 8'd0}, // R1 line
        '{3'd1, 2'd0, 2'd0, 1'b0, 8'd0, 8'd0, 8'd0, 1'b0, 8'd0, 8'd0}, // R3 disabled hit
        '{3'd1, 2'd1, 2'd0, 1'b0, 8'd1, 8'd0, 8'd0, 1'b0, 8'd0, 8'd0}, // R3 point one
        '{3'd2, 2'd0, 2'd0, 1'b0, 8'd1, 8'd0, 8'd0, 1'b0, 8'd0, 8'd0}, // R4 early exec
        '{3'd1, 2'd1, 2'd0, 1'b1, 8'd1, 8'd1, 8'd0, 1'b0, 8'd0, 8'd0}, // R3 point two
        '{3'd2, 2'd0, 2'd0, 1'b1, 8'd1, 8'd1, 8'd1, 1'b0, 8'd0, 8'd0}, // R4 line draw
        '{3'd1, 2'd1, 2'd0, 1'b1, 8'd2, 8'd1, 8'd2, 1'b0, 8'd0, 8'd0}, // R5 translate
        '{3'd0, 2'd1, 2'd1, 1'b0, 8'd2, 8'd1, 8'd2, 1'b0, 8'd0, 8'd0}, // R10 circle
        '{3'd1, 2'd1, 2'd1, 1'b0, 8'd3, 8'd1, 8'd2, 1'b0, 8'd0, 8'd0}, // R3 centre
        '{3'd1, 2'd1, 2'd1, 1'b1, 8'd3, 8'd2, 8'd2, 1'b0, 8'd0, 8'd0}, // R3 rim
        '{3'd2, 2'd0, 2'd1, 1'b1, 8'd3, 8'd2, 8'd3, 1'b1, 8'd0, 8'd0}, // R4 circle draw
        '{3'd1, 2'd3, 2'd1, 1'b1, 8'd3, 8'd3, 8'd4, 1'b1, 8'd0, 8'd0}, // R6 new radius
        '{3'd1, 2'd1, 2'd1, 1'b1, 8'd4, 8'd3, 8'd5, 1'b1, 8'd0, 8'd0}, // R5 move circle
        '{3'd4, 2'd0, 2'd1, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd0, 8'd0}, // R9 clear
        '{3'd2, 2'd0, 2'd1, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd0, 8'd0}, // R9 exec ignored
        '{3'd0, 2'd2, 2'd2, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd0, 8'd0}, // R1 erase
        '{3'd1, 2'd0, 2'd2, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd1, 8'd0}, // R7 mark, no enable
        '{3'd1, 2'd1, 2'd2, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd2, 8'd0}, // R11 no strobe
        '{3'd3, 2'd0, 2'd2, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd2, 8'd1}, // R7 execute
        '{3'd3, 2'd0, 2'd2, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd2, 8'd1}, // R7 nothing pending
        '{3'd0, 2'd0, 2'd0, 1'b0, 8'd4, 8'd3, 8'd5, 1'b1, 8'd2, 8'd1}  // R1 back to line
    };

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press_mode(input int m);
        mode_btn[m] = 1'b1; wait_neg(6); mode_btn[m] = 1'b0; wait_neg(6);
    endtask

    task automatic hit(input logic en, input logic pk);
        pen_en = en; pick_second = pk; wait_neg(4);
        pen_hit = 1'b1; wait_neg(1); pen_hit = 1'b0; wait_neg(6);
        pen_en = 1'b0; pick_second = 1'b0; wait_neg(4);
    endtask

    task automatic press_x(input int which);
        case (which)
            2: exec_con_btn = 1'b1;
            3: exec_era_btn = 1'b1;
            default: erase_pt_btn = 1'b1;
        endcase
        wait_neg(6);
        exec_con_btn = 1'b0; exec_era_btn = 1'b0; erase_pt_btn = 1'b0;
        wait_neg(6);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        wait_neg(3);
        // reset state, R1
        chk("R1 reset mode", int'(mode_o), 0);
        chk("R4 reset lamp", int'(con_ready), 0);
        chk("R8 reset gate", int'(write_gate), 0);
        rst_n = 1'b1;
        wait_neg(2);

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].act)
                3'd0: press_mode(int'(TBL[i].arg));
                3'd1: hit(TBL[i].arg[0], TBL[i].arg[1]);
                default: press_x(int'(TBL[i].act));
            endcase
            chk("R1 mode", int'(mode_o), int'(TBL[i].mode));
            chk("R4 lamp", int'(con_ready), int'(TBL[i].rdy));
            chk("R3 p1 strobes", c_p1, int'(TBL[i].p1));
            chk("R3 p2 strobes", c_p2, int'(TBL[i].p2));
            chk("R5 draws", c_dr, int'(TBL[i].dr));
            chk("R6 kind", int'(draw_circle), int'(TBL[i].kind));
            chk("R7 marks", c_mk, int'(TBL[i].mk));
            chk("R7 erases", c_eg, int'(TBL[i].eg));
        end
        chk("R9 clear pulses", c_clr, 1);

        // R2: a long hold still gives one event
        hit(1'b1, 1'b0);
        exec_con_btn = 1'b1; wait_neg(40); exec_con_btn = 1'b0; wait_neg(6);
        chk("R2 single p1 on hold", c_p1, 5);
        chk("R2 no draw without lamp", c_dr, 5);

        // R1: simultaneous presses, lowest index wins
        mode_btn = 4'b1010; wait_neg(6); mode_btn = '0; wait_neg(6);
        chk("R1 priority", int'(mode_o), 1);
        chk("R10 lamp after mode", int'(con_ready), 0);

        // R8 / R11: write mode
        press_mode(3);
        chk("R1 write mode", int'(mode_o), 3);
        hit(1'b1, 1'b0);
        chk("R11 no p1 in write", c_p1, 5);
        chk("R11 no p2 in write", c_p2, 3);
        chk("R11 no mark in write", c_mk, 2);
        begin
            int base;
            base = c_wg;
            pen_en = 1'b1;
            wait_neg(2);
            chk("R8 gate not before 3 edges", int'(write_gate), 0);
            wait_neg(1);
            chk("R8 gate at 3 edges", int'(write_gate), 1);
            wait_neg(7);
            pen_en = 1'b0;
            wait_neg(2);
            chk("R8 gate still open", int'(write_gate), 1);
            wait_neg(1);
            chk("R8 gate closed", int'(write_gate), 0);
            wait_neg(3);
            chk("R8 gate duration", c_wg - base, 10);
        end
        finish_run();
    end
endmodule